// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block watches 32 digital input lines and lets a host read all of them through a small 32-bit register bus. The low 16 lines can also raise an interrupt when their state changes. Two mask registers choose the channels that take part. One mask holds the channels that react to a rising edge or a high level. The other holds the channels that react to a falling edge or a low level.

A control register picks one of two combining schemes and holds the global interrupt enable. In "any" mode, a selected edge on any enabled channel raises the interrupt. In "all" mode, the interrupt is raised only when every enabled channel sits at its chosen level at the same moment. After an "all" trigger, the block waits for a level change on a selected channel before it can trigger again.

When the interrupt fires, a status register records the channels that caused it. Reading that register returns the record and clears both the record and the pending interrupt. Every input passes through a two-flop synchroniser before any other logic sees it.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irqOut` is low.
- R2: A read at byte offset 0x00 returns all 32 synchronised input lines.
- R3: The rise/high mask sits at offset 0x04 and the fall/low mask at offset 0x08. Both keep only bits 15:0, and bits 31:16 read as zero.
- R4: In the control register at offset 0x10, bit 1 selects the combining mode (0 = any/edge, 1 = all/level) and bit 2 is the interrupt enable. All other bits read as zero.
- R5: In any mode, a rising edge on a channel set in the rise mask raises `irqOut`, and the status bit of that channel is set.
- R6: In any mode, a falling edge on a channel set in the fall mask raises `irqOut`. An edge of the opposite polarity, or an edge on an unselected channel, does not.
- R7: In all mode, `irqOut` rises only when every selected channel is at its level: high for rise-mask channels, low for fall-mask channels. Status then holds all selected channels. A partial match does not fire.
- R8: After an all-mode trigger, no new trigger occurs while the condition stays true. A level change on a selected channel re-arms the trigger.
- R9: A read at offset 0x0C returns the status in bits 15:0, with zero above. The read clears the status and drops `irqOut`.
- R10: With the enable bit at 0, no interrupt is raised and no status is recorded, and the mask registers keep their values.
- R11: Writes to offsets 0x00 and 0x0C have no effect.
- R12: Lines 16 to 31 never cause an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinsIn | input | 32 | Asynchronous digital input lines |
| busAddr | input | 5 | Byte offset of the register access |
| busWrEn | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe; data appears on `busRdata` one cycle later |
| busRdata | output | 32 | Registered read data |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
The bench drives the edge mode with a single rising edge, then a single falling edge, then edges of the wrong polarity and edges on unselected or upper lines. This separates the polarity masks from each other and from the channel range. The level mode is tried in three ways. First, a partial match sets the rule for one channel's level against another's. Next, the complete match is held steady to show the lock-out. Last, a toggle of one selected line shows the re-arm. Reads with the enable cleared and writes to read-only offsets show that configuration survives and that stimulus outside the enabled path leaves no trace.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam logic [4:0] OFS_INPUT  = 5'h00;
  localparam logic [4:0] OFS_RISE   = 5'h04;
  localparam logic [4:0] OFS_FALL   = 5'h08;
  localparam logic [4:0] OFS_STATUS = 5'h0C;
  localparam logic [4:0] OFS_CTRL   = 5'h10;

  localparam int CTRL_MODE_BIT = 1;
  localparam int CTRL_EN_BIT   = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic statusClear;  // status register was read
    logic rearm;        // configuration changed, drop all-mode lockout
  } cosStrobe_t;
endpackage

// File: rtl/cos_ctrl.sv
module cos_ctrl
  import cos_pkg::*;
#(
  parameter int N_IN   = 32,
  parameter int N_COS  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdata,
  input  logic [N_IN-1:0]   syncIn,
  input  logic [N_COS-1:0]  statusQ,
  output logic [N_COS-1:0]  modeRise,
  output logic [N_COS-1:0]  modeFall,
  output logic              andMode,
  output logic              enable,
  output cosStrobe_t        strobe
);
  localparam int PAD_IN  = DATA_W - N_IN;
  localparam int PAD_COS = DATA_W - N_COS;

  logic wrRise, wrFall, wrCtrl;
  logic [DATA_W-1:0] rdNext;
  logic wdataUnused;

  assign wdataUnused = ^{busWdata[DATA_W-1:N_COS], busWdata[0]};

  assign wrRise = busWrEn && (busAddr == ADDR_W'(OFS_RISE));
  assign wrFall = busWrEn && (busAddr == ADDR_W'(OFS_FALL));
  assign wrCtrl = busWrEn && (busAddr == ADDR_W'(OFS_CTRL));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeRise <= '0;
      modeFall <= '0;
      andMode  <= 1'b0;
      enable   <= 1'b0;
    end else begin
      if (wrRise) modeRise <= busWdata[N_COS-1:0];
      if (wrFall) modeFall <= busWdata[N_COS-1:0];
      if (wrCtrl) begin
        andMode <= busWdata[CTRL_MODE_BIT];
        enable  <= busWdata[CTRL_EN_BIT];
      end
    end
  end

  always_comb begin
    strobe.statusClear = busRdEn && (busAddr == ADDR_W'(OFS_STATUS));
    strobe.rearm       = wrRise || wrFall || wrCtrl;
  end

  always_comb begin
    rdNext = '0;
    unique case (busAddr)
      ADDR_W'(OFS_INPUT):  rdNext = {{PAD_IN{1'b0}}, syncIn};
      ADDR_W'(OFS_RISE):   rdNext = {{PAD_COS{1'b0}}, modeRise};
      ADDR_W'(OFS_FALL):   rdNext = {{PAD_COS{1'b0}}, modeFall};
      ADDR_W'(OFS_STATUS): rdNext = {{PAD_COS{1'b0}}, statusQ};
      ADDR_W'(OFS_CTRL): begin
        rdNext[CTRL_MODE_BIT] = andMode;
        rdNext[CTRL_EN_BIT]   = enable;
      end
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)        busRdata <= '0;
    else if (busRdEn) busRdata <= rdNext;
  end
endmodule

// File: rtl/cos_datapath.sv
module cos_datapath
  import cos_pkg::*;
#(
  parameter int N_IN  = 32,
  parameter int N_COS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N_IN-1:0]  pinsIn,
  input  logic [N_COS-1:0] modeRise,
  input  logic [N_COS-1:0] modeFall,
  input  logic             andMode,
  input  logic             enable,
  input  cosStrobe_t       strobe,
  output logic [N_IN-1:0]  syncIn,
  output logic [N_COS-1:0] statusQ,
  output logic             fireEv,
  output logic             irqOut
);
  logic [N_IN-1:0]  metaQ;
  logic [N_COS-1:0] prevQ;
  logic [N_COS-1:0] riseV, fallV, hitOr, meetV, selected, capture;
  logic allMet, selChange, blocked, pending, andFire, orFire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      metaQ  <= '0;
      syncIn <= '0;
      prevQ  <= '0;
    end else begin
      metaQ  <= pinsIn;
      syncIn <= metaQ;
      prevQ  <= syncIn[N_COS-1:0];
    end
  end

  for (genvar i = 0; i < N_COS; i++) begin : g_chan
    assign riseV[i]    = syncIn[i] & ~prevQ[i];
    assign fallV[i]    = ~syncIn[i] & prevQ[i];
    assign hitOr[i]    = (riseV[i] & modeRise[i]) | (fallV[i] & modeFall[i]);
    assign meetV[i]    = (modeRise[i] & syncIn[i]) | (modeFall[i] & ~syncIn[i]);
    assign selected[i] = modeRise[i] | modeFall[i];
  end

  assign allMet    = (|selected) && ((meetV & selected) == selected);
  assign selChange = |((riseV | fallV) & selected);
  assign andFire   = andMode && allMet && !blocked;
  assign orFire    = !andMode && (|hitOr);
  assign fireEv    = enable && (andFire || orFire);
  assign capture   = andMode ? (meetV & selected) : hitOr;

  always_ff @(posedge clk) begin
    if (!rstN)                     blocked <= 1'b0;
    else if (strobe.rearm)         blocked <= 1'b0;
    else if (fireEv && andMode)    blocked <= 1'b1;
    else if (selChange)            blocked <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      pending <= 1'b0;
    end else if (fireEv) begin
      statusQ <= (strobe.statusClear ? '0 : statusQ) | capture;
      pending <= 1'b1;
    end else if (strobe.statusClear) begin
      statusQ <= '0;
      pending <= 1'b0;
    end
  end

  assign irqOut = pending && enable;
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_pkg::*;
#(
  parameter int N_IN   = 32,
  parameter int N_COS  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_IN-1:0]   pinsIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  logic [N_COS-1:0] modeRise, modeFall, statusQ;
  logic [N_IN-1:0]  syncIn;
  logic andMode, enable, fireEv;
  cosStrobe_t strobe;

  cos_ctrl #(.N_IN(N_IN), .N_COS(N_COS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdEn(busRdEn), .busRdata(busRdata),
    .syncIn(syncIn), .statusQ(statusQ), .modeRise(modeRise),
    .modeFall(modeFall), .andMode(andMode), .enable(enable), .strobe(strobe)
  );

  cos_datapath #(.N_IN(N_IN), .N_COS(N_COS)) u_dp (
    .clk(clk), .rstN(rstN), .pinsIn(pinsIn), .modeRise(modeRise),
    .modeFall(modeFall), .andMode(andMode), .enable(enable), .strobe(strobe),
    .syncIn(syncIn), .statusQ(statusQ), .fireEv(fireEv), .irqOut(irqOut)
  );
endmodule

// File: rtl/cos_irq_chk.sv
module cos_irq_chk #(
  parameter int N_COS  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqOut,
  input logic              enable,
  input logic              fireEv,
  input logic [N_COS-1:0]  statusQ
);
  // R10: interrupt only while enabled
  p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> enable);

  // R5: a raised interrupt always has a recorded cause
  p_irq_has_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (statusQ != '0));

  // R9: status read without a new trigger leaves nothing pending
  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(5'h0C) && !fireEv) |=> (statusQ == '0 && !irqOut));

  // R9: status data has zero upper half
  p_status_upper_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(5'h0C)) |=> (busRdata[DATA_W-1:N_COS] == '0));

  // R4: control readback has only bits 1 and 2
  p_ctrl_unused_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(5'h10)) |=> (busRdata[DATA_W-1:3] == '0 && !busRdata[0]));
endmodule

bind cos_irq_ctrl cos_irq_chk #(.N_COS(N_COS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdEn(busRdEn),
  .busRdata(busRdata), .irqOut(irqOut), .enable(enable),
  .fireEv(fireEv), .statusQ(statusQ)
);

// File: tb/tb_cos_irq_ctrl.sv
`timescale 1ns/1ps
module tb_cos_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pinsIn = '0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdata;
  logic        irqOut;
  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cos_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .pinsIn(pinsIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWdata(busWdata), .busRdEn(busRdEn),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRdEn = 1'b1;
    @(negedge clk); busRdEn = 1'b0; d = busRdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clearAll();
    logic [31:0] d;
    busWrite(5'h10, 0); busWrite(5'h04, 0); busWrite(5'h08, 0);
    pinsIn = '0; settle(); busRead(5'h0C, d);
  endtask

  task automatic tReset();
    logic [31:0] d;
    check("R1 irq", {31'b0, irqOut}, 0);
    busRead(5'h04, d); check("R1 rise", d, 0);
    busRead(5'h08, d); check("R1 fall", d, 0);
    busRead(5'h10, d); check("R1 ctrl", d, 0);
    busRead(5'h0C, d); check("R1 status", d, 0);
  endtask

  task automatic tRegs();
    logic [31:0] d;
    pinsIn = 32'hA5C3_0F96; settle();
    busRead(5'h00, d); check("R2 input", d, 32'hA5C3_0F96);
    busWrite(5'h04, 32'hFFFF_1234); busRead(5'h04, d); check("R3 rise mask", d, 32'h1234);
    busWrite(5'h08, 32'hABCD_8001); busRead(5'h08, d); check("R3 fall mask", d, 32'h8001);
    busWrite(5'h10, 32'hFFFF_FFFF); busRead(5'h10, d); check("R4 ctrl", d, 32'h6);
    clearAll();
  endtask

  task automatic tOrRise();
    logic [31:0] d;
    busWrite(5'h04, 32'h0010); busWrite(5'h10, 32'h4);
    settle(); check("R6 no idle irq", {31'b0, irqOut}, 0);
    pinsIn[4] = 1'b1; settle();
    check("R5 rise irq", {31'b0, irqOut}, 1);
    busRead(5'h0C, d); check("R5 status", d, 32'h0010);
    check("R9 irq cleared", {31'b0, irqOut}, 0);
    busRead(5'h0C, d); check("R9 status cleared", d, 0);
    pinsIn[4] = 1'b0; settle();
    check("R6 wrong polarity", {31'b0, irqOut}, 0);
    clearAll();
  endtask

  task automatic tOrFall();
    logic [31:0] d;
    pinsIn[9] = 1'b1; pinsIn[2] = 1'b1; settle();
    busWrite(5'h08, 32'h0200); busWrite(5'h10, 32'h4);
    pinsIn[2] = 1'b0; settle();
    check("R6 unselected", {31'b0, irqOut}, 0);
    pinsIn[9] = 1'b0; settle();
    check("R6 fall irq", {31'b0, irqOut}, 1);
    busRead(5'h0C, d); check("R6 status", d, 32'h0200);
    clearAll();
  endtask

  task automatic tAnd();
    logic [31:0] d;
    pinsIn[1] = 1'b1; settle();
    busWrite(5'h04, 32'h1); busWrite(5'h08, 32'h2); busWrite(5'h10, 32'h6);
    pinsIn[0] = 1'b1; settle();
    check("R7 partial", {31'b0, irqOut}, 0);
    pinsIn[1] = 1'b0; settle();
    check("R7 all met", {31'b0, irqOut}, 1);
    busRead(5'h0C, d); check("R7 status", d, 32'h3);
    settle();
    check("R8 locked", {31'b0, irqOut}, 0);
    busRead(5'h0C, d); check("R8 no status", d, 0);
    pinsIn[1] = 1'b1; settle();
    pinsIn[1] = 1'b0; settle();
    check("R8 rearmed", {31'b0, irqOut}, 1);
    clearAll();
  endtask

  task automatic tDisable();
    logic [31:0] d;
    busWrite(5'h04, 32'h0008); busWrite(5'h10, 32'h0);
    pinsIn[3] = 1'b1; settle();
    check("R10 no irq", {31'b0, irqOut}, 0);
    busRead(5'h0C, d); check("R10 no status", d, 0);
    busRead(5'h04, d); check("R10 mask kept", d, 32'h0008);
    clearAll();
  endtask

  task automatic tReadOnly();
    logic [31:0] d;
    pinsIn = 32'h0000_00F0; settle();
    busWrite(5'h00, 32'hFFFF_FFFF); busWrite(5'h0C, 32'hFFFF_FFFF);
    busRead(5'h00, d); check("R11 input ro", d, 32'h0000_00F0);
    busRead(5'h0C, d); check("R11 status ro", d, 0);
    check("R11 irq", {31'b0, irqOut}, 0);
    clearAll();
  endtask

  task automatic tUpper();
    logic [31:0] d;
    busWrite(5'h04, 32'hFFFF_FFFF); busWrite(5'h08, 32'hFFFF_FFFF); busWrite(5'h10, 32'h4);
    pinsIn[20] = 1'b1; settle(); pinsIn[31] = 1'b1; settle();
    check("R12 upper rise", {31'b0, irqOut}, 0);
    pinsIn[20] = 1'b0; settle();
    check("R12 upper fall", {31'b0, irqOut}, 0);
    busRead(5'h0C, d); check("R12 status", d, 0);
    clearAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset(); tRegs(); tOrRise(); tOrFall(); tAnd(); tDisable(); tReadOnly(); tUpper();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule